// File: doc/BRIEF.md
# Two-Tier Prioritized Interrupt Controller

This block gathers interrupt events from a configurable number of 32-bit source sets and raises two processor interrupt requests. Each source line is edge-captured into a sticky pending bit. Software clears a pending bit by writing a one to its position, so writing back a value just read clears exactly the events that were seen.

Most sources feed the low tier. That request goes up when any pending source also has its per-bit enable set. A fixed group of sources is instead tied to one of fifteen priority levels, 1 to 15, with 15 the most urgent. These sources raise the high-tier request when their level's bit is set in a level mask. A 4-bit vector names the most urgent enabled level that has a pending source. A global enable bit can silence both requests without losing any pending state.

Control and status use a plain one-cycle register port: address, write data and write strobe in, read data out. Reads are combinational. Writes land on the next rising clock edge. The port has no valid/ready handshake and never applies back-pressure: every write strobe is accepted in the cycle it is presented.

Top module: `icu_two_tier`

## Requirements
- R1: After reset every pending, enable and control bit is zero, both interrupt outputs are low and the vector reads 0.
- R2: A 0-to-1 transition on a source input sets its pending bit, which reads 1 from the next cycle on. A source held high does not set the bit again once it has been cleared.
- R3: Writing to a set's pending register (address 2+2*s) clears exactly the bits written as 1 and leaves every other pending bit unchanged.
- R4: When a new rising edge and a clearing write hit the same pending bit in the same cycle, the bit ends up set.
- R5: The low-tier output equals the global enable ANDed with the OR, over all sources that have no priority level, of pending AND enable (enable register at address 3+2*s).
- R6: A source with a priority level never drives the low-tier output, whatever its enable bit holds.
- R7: The high-tier output is high when the global enable is set and some pending prioritized source has its level bit n set in the mask. With a zero mask it stays low.
- R8: The vector equals the highest level n that has both a pending source and mask bit n set. It is 0 when no such level exists, and it is not gated by the global enable.
- R9: With the global enable clear both interrupt outputs are low, and pending bits are kept.
- R10: The status register (address 1) reads bit 31 = high-tier output, bit 30 = low-tier output, bits 3:0 = vector, all other bits 0.
- R11: The control register (address 0) holds the global enable in bit 31 and mask bits 15:1, where bit n enables level n. Bit 0 and the unused bits read 0, and reads are valid in the same cycle as the address.
- R12: Level map: set 2 bits 31 and 30 map to level 15, bit 29 to 14, bit 28 to 13, bits 9 and 8 to 1; set 0 bits 20, 21 and 22 map to levels 4, 3 and 2. Several sources sharing one level each raise it. All other sources have no level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_i | input | NSETS*32 | Source event lines; set s occupies bits s*32+31 down to s*32 |
| reg_addr_i | input | AW | Register address |
| reg_wdata_i | input | 32 | Register write data |
| reg_we_i | input | 1 | Write strobe |
| reg_rdata_o | output | 32 | Combinational read data |
| irq_high_o | output | 1 | High-tier interrupt request |
| irq_low_o | output | 1 | Low-tier interrupt request |
| irq_vec_o | output | 4 | Most urgent active enabled level |

## Verification
A source edge driven before clock edge k appears in its pending bit, in both outputs and in the vector after edge k. A register write presented before edge k takes effect at edge k. Register reads are due in the same cycle as the address.

The driver changes inputs on falling edges and waits out the capturing rising edge before it queues an expected item. The monitor compares that item two nanoseconds after the following falling edge, once the combinational read path has settled.

// File: rtl/icu_pkg.sv
package icu_pkg;
  localparam int WORD   = 32;
  localparam int NLEVEL = 16;  // level 0 means "no level"

  // Fixed priority assignment of sources; 0 = low tier only.
  function automatic logic [3:0] level_of(input int s, input int b);
    logic [3:0] l;
    l = 4'd0;
    if (s == 2) begin
      if (b == 31 || b == 30) l = 4'd15;
      else if (b == 29)       l = 4'd14;
      else if (b == 28)       l = 4'd13;
      else if (b == 9 || b == 8) l = 4'd1;
    end else if (s == 0) begin
      if (b == 20)      l = 4'd4;
      else if (b == 21) l = 4'd3;
      else if (b == 22) l = 4'd2;
    end
    return l;
  endfunction

  function automatic logic [WORD-1:0] level_mask(input int s, input int l);
    logic [WORD-1:0] m;
    for (int b = 0; b < WORD; b++) m[b] = (int'(level_of(s, b)) == l);
    return m;
  endfunction

  typedef struct packed {
    logic              gen_en;
    logic [NLEVEL-1:1] lvl_mask;
  } ctrl_t;
endpackage

// File: rtl/icu_source_set.sv
module icu_source_set
  import icu_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [WORD-1:0] src_i,
  input  logic            clr_we_i,
  input  logic            en_we_i,
  input  logic [WORD-1:0] wdata_i,
  output logic [WORD-1:0] pend_o,
  output logic [WORD-1:0] en_o
);
  logic [WORD-1:0] prev_q;
  logic [WORD-1:0] rise;
  logic [WORD-1:0] clr;

  assign rise = src_i & ~prev_q;
  assign clr  = clr_we_i ? wdata_i : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q <= '0;
      pend_o <= '0;
      en_o   <= '0;
    end else begin
      prev_q <= src_i;
      pend_o <= (pend_o & ~clr) | rise;  // new event wins over clear
      if (en_we_i) en_o <= wdata_i;
    end
  end
endmodule

// File: rtl/icu_level_merge.sv
module icu_level_merge
  import icu_pkg::*;
#(
  parameter int NSETS = 3
) (
  input  logic [NSETS*WORD-1:0] pend_i,
  input  logic [NSETS*WORD-1:0] en_i,
  output logic [NLEVEL-1:0]     lvl_act_o,
  output logic                  low_hit_o
);
  always_comb begin
    lvl_act_o = '0;
    low_hit_o = 1'b0;
    for (int s = 0; s < NSETS; s++) begin
      low_hit_o = low_hit_o |
        (|(pend_i[s*WORD +: WORD] & en_i[s*WORD +: WORD] & level_mask(s, 0)));
      for (int l = 1; l < NLEVEL; l++)
        lvl_act_o[l] = lvl_act_o[l] | (|(pend_i[s*WORD +: WORD] & level_mask(s, l)));
    end
  end
endmodule

// File: rtl/icu_prio_enc.sv
module icu_prio_enc
  import icu_pkg::*;
(
  input  logic [NLEVEL-1:0] req_i,
  output logic [3:0]        vec_o
);
  always_comb begin
    vec_o = 4'd0;
    for (int i = 1; i < NLEVEL; i++)
      if (req_i[i]) vec_o = 4'(i);
  end
endmodule

// File: rtl/icu_two_tier.sv
module icu_two_tier
  import icu_pkg::*;
#(
  parameter int NSETS = 3,
  parameter int AW    = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NSETS*32-1:0]   src_i,
  input  logic [AW-1:0]         reg_addr_i,
  input  logic [31:0]           reg_wdata_i,
  input  logic                  reg_we_i,
  output logic [31:0]           reg_rdata_o,
  output logic                  irq_high_o,
  output logic                  irq_low_o,
  output logic [3:0]            irq_vec_o
);
  localparam logic [AW-1:0] A_CTRL = AW'(0);
  localparam logic [AW-1:0] A_STAT = AW'(1);

  ctrl_t                  ctrl_q;
  logic                   gen_en;
  logic [NSETS*WORD-1:0]  pend_flat;
  logic [NSETS*WORD-1:0]  en_flat;
  logic [NLEVEL-1:0]      lvl_act;
  logic [NLEVEL-1:0]      lvl_en;
  logic                   low_hit;

  assign gen_en = ctrl_q.gen_en;

  always_ff @(posedge clk) begin
    if (!rst_n) ctrl_q <= '0;
    else if (reg_we_i && reg_addr_i == A_CTRL)
      ctrl_q <= '{gen_en: reg_wdata_i[31], lvl_mask: reg_wdata_i[NLEVEL-1:1]};
  end

  for (genvar s = 0; s < NSETS; s++) begin : g_set
    icu_source_set u_set (
      .clk      (clk),
      .rst_n    (rst_n),
      .src_i    (src_i[s*WORD +: WORD]),
      .clr_we_i (reg_we_i && reg_addr_i == AW'(2 + 2*s)),
      .en_we_i  (reg_we_i && reg_addr_i == AW'(3 + 2*s)),
      .wdata_i  (reg_wdata_i),
      .pend_o   (pend_flat[s*WORD +: WORD]),
      .en_o     (en_flat[s*WORD +: WORD])
    );
  end

  icu_level_merge #(.NSETS(NSETS)) u_merge (
    .pend_i    (pend_flat),
    .en_i      (en_flat),
    .lvl_act_o (lvl_act),
    .low_hit_o (low_hit)
  );

  assign lvl_en = lvl_act & {ctrl_q.lvl_mask, 1'b0};

  icu_prio_enc u_enc (
    .req_i (lvl_en),
    .vec_o (irq_vec_o)
  );

  assign irq_high_o = gen_en & (|lvl_en);
  assign irq_low_o  = gen_en & low_hit;

  always_comb begin
    reg_rdata_o = '0;
    if (reg_addr_i == A_CTRL)
      reg_rdata_o = {ctrl_q.gen_en, 15'd0, ctrl_q.lvl_mask, 1'b0};
    else if (reg_addr_i == A_STAT)
      reg_rdata_o = {irq_high_o, irq_low_o, 26'd0, irq_vec_o};
    for (int s = 0; s < NSETS; s++) begin
      if (reg_addr_i == AW'(2 + 2*s)) reg_rdata_o = pend_flat[s*WORD +: WORD];
      if (reg_addr_i == AW'(3 + 2*s)) reg_rdata_o = en_flat[s*WORD +: WORD];
    end
  end
endmodule

// File: rtl/icu_two_tier_chk.sv
module icu_two_tier_chk #(
  parameter int NSETS = 3
) (
  input logic                clk,
  input logic                rst_n,
  input logic [NSETS*32-1:0] src_i,
  input logic [NSETS*32-1:0] pend_flat,
  input logic                gen_en,
  input logic                irq_high_o,
  input logic                irq_low_o,
  input logic [3:0]          irq_vec_o
);
  // R9: outputs silent while globally disabled
  assert_gate_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !gen_en |-> (!irq_high_o && !irq_low_o));

  // R7: a high-tier request always names a real level
  assert_vec_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_high_o |-> (irq_vec_o != 4'd0));

  // R8: enabled controller with no high request reports vector 0
  assert_vec_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (gen_en && !irq_high_o) |-> (irq_vec_o == 4'd0));

  // R2: a pending bit only appears where its source was high at the capturing edge
  assert_rise_source_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend_flat & ~$past(pend_flat)) & ~$past(src_i)) == '0);
endmodule

bind icu_two_tier icu_two_tier_chk #(.NSETS(NSETS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .src_i      (src_i),
  .pend_flat  (pend_flat),
  .gen_en     (gen_en),
  .irq_high_o (irq_high_o),
  .irq_low_o  (irq_low_o),
  .irq_vec_o  (irq_vec_o)
);

// File: tb/icu_two_tier_bench.sv
`timescale 1ns/1ps
module icu_two_tier_bench;
  localparam int NSETS = 3;
  localparam int AW    = 4;

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic [NSETS*32-1:0] src = '0;
  logic [AW-1:0]       addr = '0;
  logic [31:0]         wdata = '0;
  logic                we = 1'b0;
  logic [31:0]         rdata;
  logic                irq_high, irq_low;
  logic [3:0]          vec;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  typedef struct {
    logic [31:0] rd;
    logic        hi;
    logic        lo;
    logic [3:0]  v;
    string       tag;
  } exp_t;
  exp_t q[$];

  always #4 clk = ~clk;  // 125 MHz

  icu_two_tier #(.NSETS(NSETS), .AW(AW)) u_icu_two_tier (
    .clk(clk), .rst_n(rst_n), .src_i(src),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_we_i(we),
    .reg_rdata_o(rdata), .irq_high_o(irq_high), .irq_low_o(irq_low),
    .irq_vec_o(vec)
  );

  // Monitor: pops expected items and compares with observed outputs
  always @(negedge clk) begin
    #2;
    while (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (rdata !== e.rd || irq_high !== e.hi || irq_low !== e.lo || vec !== e.v) begin
        failures++;
        $display("FAIL %s: got rd=%h hi=%b lo=%b vec=%0d, expected rd=%h hi=%b lo=%b vec=%0d",
                 e.tag, rdata, irq_high, irq_low, vec, e.rd, e.hi, e.lo, e.v);
      end
    end
  end

  task automatic chk(input int a, input logic [31:0] rd, input logic hi,
                     input logic lo, input logic [3:0] v, input string tag);
    exp_t e;
    @(negedge clk);
    addr = AW'(a);
    e.rd = rd; e.hi = hi; e.lo = lo; e.v = v; e.tag = tag;
    q.push_back(e);
    @(posedge clk);
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    addr = AW'(a); wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic pulse(input int s, input int b);
    @(negedge clk);
    src[s*32+b] = 1'b1;
    @(negedge clk);
    src[s*32+b] = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    chk(0, 32'h0, 0, 0, 0, "R1 ctrl");
    chk(1, 32'h0, 0, 0, 0, "R1 stat");
    chk(4, 32'h0, 0, 0, 0, "R1 pend1");
    // R2/R5: low-tier edge capture
    wr(5, 32'h0000_0020);
    wr(0, 32'h8000_0000);
    pulse(1, 5);
    chk(4, 32'h0000_0020, 0, 1, 0, "R2 R5 pend1 bit5");
    chk(1, 32'h4000_0000, 0, 1, 0, "R10 status low");
    // R3: clear
    wr(4, 32'h0000_0020);
    chk(4, 32'h0, 0, 0, 0, "R3 clear bit5");
    wr(5, 32'h0000_0060);
    pulse(1, 5);
    pulse(1, 6);
    wr(4, 32'h0000_0040);
    chk(4, 32'h0000_0020, 0, 1, 0, "R3 only bit6 cleared");
    // R2: held source does not re-arm
    @(negedge clk); src[32+7] = 1'b1;
    repeat (2) @(negedge clk);
    chk(4, 32'h0000_00A0, 0, 1, 0, "R2 held source captured");
    wr(4, 32'h0000_0080);
    chk(4, 32'h0000_0020, 0, 1, 0, "R2 held source not re-set");
    @(negedge clk); src[32+7] = 1'b0;
    // R4: event beats clear
    @(negedge clk);
    src[32+9] = 1'b1; addr = AW'(4); wdata = 32'h0000_0200; we = 1'b1;
    @(negedge clk);
    we = 1'b0; src[32+9] = 1'b0;
    chk(4, 32'h0000_0220, 0, 1, 0, "R4 event wins");
    // R9: global disable
    wr(0, 32'h0);
    chk(4, 32'h0000_0220, 0, 0, 0, "R9 low gated, pending kept");
    wr(0, 32'h8000_0000);
    wr(4, 32'hFFFF_FFFF);
    chk(4, 32'h0, 0, 0, 0, "R5 all cleared low drops");
    // R6/R7: prioritized source, zero mask
    wr(3, 32'h0010_0000);
    pulse(0, 20);
    chk(2, 32'h0010_0000, 0, 0, 0, "R6 R7 level source zero mask");
    wr(0, 32'h8000_0010);
    chk(1, 32'h8000_0004, 1, 0, 4, "R7 level4 enabled");
    // R8: ordering
    pulse(2, 29);
    chk(6, 32'h2000_0000, 1, 0, 4, "R8 masked level14 ignored");
    wr(0, 32'h8000_4010);
    chk(1, 32'h8000_000E, 1, 0, 14, "R8 level14 wins");
    wr(0, 32'h8000_C011);
    chk(0, 32'h8000_C010, 1, 0, 14, "R11 ctrl readback");
    pulse(2, 31);
    chk(1, 32'h8000_000F, 1, 0, 15, "R8 level15 wins");
    wr(6, 32'h8000_0000);
    pulse(2, 30);
    chk(6, 32'h6000_0000, 1, 0, 15, "R12 shared level15");
    wr(6, 32'hFFFF_FFFF);
    chk(1, 32'h8000_0004, 1, 0, 4, "R8 back to level4");
    // R12: lowest level source
    pulse(2, 8);
    wr(0, 32'h8000_0002);
    chk(1, 32'h8000_0001, 1, 0, 1, "R12 level1 source");
    wr(7, 32'h0000_0100);
    chk(7, 32'h0000_0100, 1, 0, 1, "R6 enabled level source no low");
    // R9: high tier gated, vector kept
    wr(0, 32'h0000_0002);
    chk(1, 32'h0000_0001, 0, 0, 1, "R9 high gated");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule